// File: doc/BRIEF.md
# RTC Register and Interrupt Unit

This block is the software-visible register front end of a real-time clock. A host reaches it over a plain 32-bit read/write bus using byte offsets that are multiples of four. Software uses it to load a new time, trim the oscillator, read the running seconds and sub-second tick count, arm an alarm, and manage two interrupt sources. The timekeeping core sits behind the block. The core receives a one-cycle load strobe with the new time, the calibration word and the control enables. In return the core supplies a once-per-second pulse, the 32-bit seconds count and the tick count.

Each interrupt source has a status bit, and a write of one clears that bit. Software turns sources on by writing ones to one register and turns them off by writing ones to another, so no read-modify-write is needed. A third register shows which sources are on. The seconds status bit is set on the first seconds pulse after a time load. Software can therefore tell whether a freshly written time has taken effect. Until it has, software reads the pending time from the set-time readback register.

Top module: `rtc_reg_front`

## Requirements
- R1: After reset the set-time readback (0x04), calibration readback (0x0C), alarm (0x18), status (0x20), mask (0x24) and control (0x40) registers all read zero, and both interrupt outputs are low.
- R2: A write to 0x00 stores the word, which reads back at 0x04. On the clock after that write, `coreLoad` is high for exactly one cycle and `coreLoadVal` carries the written word.
- R3: A write to 0x08 stores its low 21 bits. Those bits read back at 0x0C with the upper bits zero and drive `calibOut`.
- R4: A read of 0x10 returns `coreSeconds`. A read of 0x14 returns `coreTick` in bits 15:0, with zeros above.
- R5: The alarm register at 0x18 is readable and writable over all 32 bits.
- R6: Status bit 0 (seconds) is set by `secPulse`. Status bit 1 (alarm) is set only when `secPulse` is high and `coreSeconds` equals the alarm register; a match without a pulse does not set it.
- R7: Writing to 0x20 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R8: Writing ones to 0x28 turns those sources on (bit 0 seconds, bit 1 alarm). Writing ones to 0x2C turns them off. Bits written as 0 to either register have no effect. 0x24 reads the current enables in bits 1:0.
- R9: `irqSec` is high exactly when status bit 0 and enable bit 0 are both set. `irqAlarm` is high exactly when status bit 1 and enable bit 1 are both set.
- R10: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R11: In the control register at 0x40, only bit 31 (battery switch enable, output `battEn`) and bit 24 (oscillator enable, output `oscEn`) are stored. All other bits read zero.
- R12: Reads of unmapped or misaligned offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busRdEn | input | 1 | Read enable; read data is zero when low |
| busAddr | input | 8 | Byte offset |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, combinational from the offset |
| secPulse | input | 1 | One-cycle pulse from the core per second |
| coreSeconds | input | 32 | Running seconds count from the core |
| coreTick | input | 16 | Sub-second tick count from the core |
| coreLoad | output | 1 | One-cycle strobe to load a new time |
| coreLoadVal | output | 32 | Time value to load |
| calibOut | output | 21 | Calibration word to the core |
| oscEn | output | 1 | Oscillator enable |
| battEn | output | 1 | Battery switch enable |
| irqSec | output | 1 | Seconds interrupt |
| irqAlarm | output | 1 | Alarm interrupt |

## Verification
The seconds pulse from the core, together with an alarm match, can set status bits in the same cycle that a software write-one-to-clear to the status register targets those bits. The bench raises `secPulse` with `coreSeconds` equal to the alarm value during the same clock as a status write of 0x3. It then reads the status register and expects both bits set. A separate case clears with no pulse present and expects the bits to fall, so a design in which either side always wins cannot pass both cases.

// File: rtl/rtc_reg_pkg.sv
package rtc_reg_pkg;
  localparam int DATA_W  = 32;
  localparam int N_IRQ   = 2;
  localparam int IRQ_SEC = 0;
  localparam int IRQ_ALM = 1;

  localparam int OFS_SET_WR  = 'h00;
  localparam int OFS_SET_RD  = 'h04;
  localparam int OFS_CAL_WR  = 'h08;
  localparam int OFS_CAL_RD  = 'h0C;
  localparam int OFS_CUR_SEC = 'h10;
  localparam int OFS_CUR_TCK = 'h14;
  localparam int OFS_ALARM   = 'h18;
  localparam int OFS_STATUS  = 'h20;
  localparam int OFS_MASK    = 'h24;
  localparam int OFS_ENABLE  = 'h28;
  localparam int OFS_DISABLE = 'h2C;
  localparam int OFS_CTRL    = 'h40;

  localparam int CTRL_BATT_BIT = 31;
  localparam int CTRL_OSC_BIT  = 24;

  typedef enum logic [3:0] {
    RD_NONE, RD_SETTIME, RD_CALIB, RD_CURSEC, RD_TICK,
    RD_ALARM, RD_STATUS, RD_MASK, RD_CTRL
  } rdSel_e;

  typedef struct packed {
    logic wrSetTime;
    logic wrCalib;
    logic wrAlarm;
    logic clrStat;
    logic wrEnable;
    logic wrDisable;
    logic wrCtrl;
  } regStrobe_t;
endpackage

// File: rtl/rtc_reg_ctrl.sv
module rtc_reg_ctrl
  import rtc_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe,
  output rdSel_e            rdSel
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    strobe           = '0;
    strobe.wrSetTime = busWrEn && hit(busAddr, OFS_SET_WR);
    strobe.wrCalib   = busWrEn && hit(busAddr, OFS_CAL_WR);
    strobe.wrAlarm   = busWrEn && hit(busAddr, OFS_ALARM);
    strobe.clrStat   = busWrEn && hit(busAddr, OFS_STATUS);
    strobe.wrEnable  = busWrEn && hit(busAddr, OFS_ENABLE);
    strobe.wrDisable = busWrEn && hit(busAddr, OFS_DISABLE);
    strobe.wrCtrl    = busWrEn && hit(busAddr, OFS_CTRL);
  end

  always_comb begin
    rdSel = RD_NONE;
    if (busRdEn) begin
      if      (hit(busAddr, OFS_SET_RD))  rdSel = RD_SETTIME;
      else if (hit(busAddr, OFS_CAL_RD))  rdSel = RD_CALIB;
      else if (hit(busAddr, OFS_CUR_SEC)) rdSel = RD_CURSEC;
      else if (hit(busAddr, OFS_CUR_TCK)) rdSel = RD_TICK;
      else if (hit(busAddr, OFS_ALARM))   rdSel = RD_ALARM;
      else if (hit(busAddr, OFS_STATUS))  rdSel = RD_STATUS;
      else if (hit(busAddr, OFS_MASK))    rdSel = RD_MASK;
      else if (hit(busAddr, OFS_CTRL))    rdSel = RD_CTRL;
    end
  end
endmodule

// File: rtl/rtc_reg_dp.sv
module rtc_reg_dp
  import rtc_reg_pkg::*;
#(
  parameter int TICK_W  = 16,
  parameter int CALIB_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  input  logic              secPulse,
  input  logic [DATA_W-1:0] coreSeconds,
  input  logic [TICK_W-1:0] coreTick,
  output logic              coreLoad,
  output logic [DATA_W-1:0] coreLoadVal,
  output logic [CALIB_W-1:0] calibOut,
  output logic              oscEn,
  output logic              battEn,
  output logic              irqSec,
  output logic              irqAlarm
);
  logic [DATA_W-1:0]  setTimeQ, alarmQ;
  logic [CALIB_W-1:0] calibQ;
  logic               loadQ, battQ, oscQ;
  logic [N_IRQ-1:0]   hwSet, statusQ, enQ;

  assign hwSet[IRQ_SEC] = secPulse;
  assign hwSet[IRQ_ALM] = secPulse && (coreSeconds == alarmQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setTimeQ <= '0;
      alarmQ   <= '0;
      calibQ   <= '0;
      loadQ    <= 1'b0;
      battQ    <= 1'b0;
      oscQ     <= 1'b0;
    end else begin
      loadQ <= strobe.wrSetTime;
      if (strobe.wrSetTime) setTimeQ <= wData;
      if (strobe.wrAlarm)   alarmQ   <= wData;
      if (strobe.wrCalib)   calibQ   <= wData[CALIB_W-1:0];
      if (strobe.wrCtrl) begin
        battQ <= wData[CTRL_BATT_BIT];
        oscQ  <= wData[CTRL_OSC_BIT];
      end
    end
  end

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_irq
    logic stQ, enBitQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stQ    <= 1'b0;
        enBitQ <= 1'b0;
      end else begin
        if (hwSet[gi])                         stQ <= 1'b1;
        else if (strobe.clrStat && wData[gi])  stQ <= 1'b0;
        if (strobe.wrEnable && wData[gi])      enBitQ <= 1'b1;
        else if (strobe.wrDisable && wData[gi]) enBitQ <= 1'b0;
      end
    end
    assign statusQ[gi] = stQ;
    assign enQ[gi]     = enBitQ;
  end

  assign irqSec      = statusQ[IRQ_SEC] & enQ[IRQ_SEC];
  assign irqAlarm    = statusQ[IRQ_ALM] & enQ[IRQ_ALM];
  assign coreLoad    = loadQ;
  assign coreLoadVal = setTimeQ;
  assign calibOut    = calibQ;
  assign oscEn       = oscQ;
  assign battEn      = battQ;

  always_comb begin
    rData = '0;
    case (rdSel)
      RD_SETTIME: rData = setTimeQ;
      RD_CALIB:   rData = DATA_W'(calibQ);
      RD_CURSEC:  rData = coreSeconds;
      RD_TICK:    rData = DATA_W'(coreTick);
      RD_ALARM:   rData = alarmQ;
      RD_STATUS:  rData = DATA_W'(statusQ);
      RD_MASK:    rData = DATA_W'(enQ);
      RD_CTRL: begin
        rData[CTRL_BATT_BIT] = battQ;
        rData[CTRL_OSC_BIT]  = oscQ;
      end
      default:    rData = '0;
    endcase
  end

  // R2: a set-time write is followed by exactly one load strobe
  p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSetTime |=> coreLoad && (coreLoadVal == $past(wData)));

  // R6: alarm status can only rise on a seconds pulse
  p_alarm_on_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[IRQ_ALM]) |-> $past(secPulse));

  // R7: a clear with no competing set drops the bit
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrStat && wData[IRQ_SEC] && !secPulse) |=> !statusQ[IRQ_SEC]);

  // R8: a disable write silences the alarm output on the next cycle
  p_disable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrDisable && wData[IRQ_ALM] && !strobe.wrEnable) |=> !irqAlarm);

  // R10: hardware set beats a simultaneous software clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrStat && wData[IRQ_SEC] && secPulse) |=> statusQ[IRQ_SEC]);
endmodule

// File: rtl/rtc_reg_front.sv
module rtc_reg_front
  import rtc_reg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int TICK_W  = 16,
  parameter int CALIB_W = 21
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWData,
  output logic [31:0]        busRData,
  input  logic               secPulse,
  input  logic [31:0]        coreSeconds,
  input  logic [TICK_W-1:0]  coreTick,
  output logic               coreLoad,
  output logic [31:0]        coreLoadVal,
  output logic [CALIB_W-1:0] calibOut,
  output logic               oscEn,
  output logic               battEn,
  output logic               irqSec,
  output logic               irqAlarm
);
  regStrobe_t strobe;
  rdSel_e     rdSel;

  rtc_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .strobe(strobe), .rdSel(rdSel)
  );

  rtc_reg_dp #(.TICK_W(TICK_W), .CALIB_W(CALIB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel),
    .wData(busWData), .rData(busRData),
    .secPulse(secPulse), .coreSeconds(coreSeconds), .coreTick(coreTick),
    .coreLoad(coreLoad), .coreLoadVal(coreLoadVal), .calibOut(calibOut),
    .oscEn(oscEn), .battEn(battEn), .irqSec(irqSec), .irqAlarm(irqAlarm)
  );
endmodule

// File: tb/rtc_reg_front_bench.sv
`timescale 1ns/1ps
module rtc_reg_front_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWData = '0, busRData;
  logic        secPulse = 1'b0;
  logic [31:0] coreSeconds = '0;
  logic [15:0] coreTick = '0;
  logic        coreLoad, oscEn, battEn, irqSec, irqAlarm;
  logic [31:0] coreLoadVal;
  logic [20:0] calibOut;
  int nTests = 0, nFail = 0;

  always #4 clk = ~clk;

  rtc_reg_front u_rtc_reg_front (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .secPulse(secPulse), .coreSeconds(coreSeconds), .coreTick(coreTick),
    .coreLoad(coreLoad), .coreLoadVal(coreLoadVal), .calibOut(calibOut),
    .oscEn(oscEn), .battEn(battEn), .irqSec(irqSec), .irqAlarm(irqAlarm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRData;
    busRdEn = 1'b0;
  endtask

  task automatic pulseSec();
    @(negedge clk); secPulse = 1'b1;
    @(negedge clk); secPulse = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic tReset();
    readCheck("R1 settime", 8'h04, 0);
    readCheck("R1 calib", 8'h0C, 0);
    readCheck("R1 alarm", 8'h18, 0);
    readCheck("R1 status", 8'h20, 0);
    readCheck("R1 mask", 8'h24, 0);
    readCheck("R1 ctrl", 8'h40, 0);
    check("R1 irqs", {30'b0, irqSec, irqAlarm}, 0);
  endtask

  task automatic tSetTime();
    busWrite(8'h00, 32'h1234_5678);
    check("R2 load high", {31'b0, coreLoad}, 1);
    check("R2 load value", coreLoadVal, 32'h1234_5678);
    @(negedge clk);
    check("R2 load one cycle", {31'b0, coreLoad}, 0);
    readCheck("R2 readback", 8'h04, 32'h1234_5678);
  endtask

  task automatic tCalib();
    busWrite(8'h08, 32'hFFFF_FFFF);
    readCheck("R3 readback", 8'h0C, 32'h001F_FFFF);
    check("R3 calibOut", {11'b0, calibOut}, 32'h001F_FFFF);
    busWrite(8'h08, 32'h0000_7FFF);
    readCheck("R3 readback2", 8'h0C, 32'h0000_7FFF);
  endtask

  task automatic tCurrent();
    coreSeconds = 32'hCAFE_0001; coreTick = 16'hBEEF;
    readCheck("R4 seconds", 8'h10, 32'hCAFE_0001);
    readCheck("R4 tick", 8'h14, 32'h0000_BEEF);
  endtask

  task automatic tAlarmReg();
    busWrite(8'h18, 32'hA5A5_0100);
    readCheck("R5 alarm", 8'h18, 32'hA5A5_0100);
    busWrite(8'h18, 32'h0000_0100);
    readCheck("R5 alarm2", 8'h18, 32'h0000_0100);
  endtask

  task automatic tStatus();
    coreSeconds = 32'h50;
    pulseSec();
    readCheck("R6 sec only", 8'h20, 1);
    busWrite(8'h20, 0);
    readCheck("R7 write zero keeps", 8'h20, 1);
    busWrite(8'h20, 1);
    readCheck("R7 clear", 8'h20, 0);
    coreSeconds = 32'h100;
    repeat (3) @(negedge clk);
    readCheck("R6 match without pulse", 8'h20, 0);
    pulseSec();
    readCheck("R6 alarm on pulse", 8'h20, 3);
    busWrite(8'h20, 2);
    readCheck("R7 partial clear", 8'h20, 1);
    busWrite(8'h20, 3);
    readCheck("R7 clear all", 8'h20, 0);
  endtask

  task automatic tEnable();
    busWrite(8'h28, 3);
    readCheck("R8 enable", 8'h24, 3);
    busWrite(8'h2C, 1);
    readCheck("R8 disable", 8'h24, 2);
    busWrite(8'h28, 0);
    busWrite(8'h2C, 0);
    readCheck("R8 zero no effect", 8'h24, 2);
  endtask

  task automatic tIrq();
    coreSeconds = 32'h100;
    pulseSec();
    check("R9 alarm irq", {31'b0, irqAlarm}, 1);
    check("R9 sec irq off", {31'b0, irqSec}, 0);
    busWrite(8'h28, 1);
    check("R9 sec irq on", {31'b0, irqSec}, 1);
    busWrite(8'h20, 3);
    check("R9 irqs cleared", {30'b0, irqSec, irqAlarm}, 0);
    busWrite(8'h2C, 3);
  endtask

  task automatic tCollide();
    coreSeconds = 32'h100;
    @(negedge clk);
    secPulse = 1'b1; busWrEn = 1'b1; busAddr = 8'h20; busWData = 3;
    @(negedge clk);
    secPulse = 1'b0; busWrEn = 1'b0;
    readCheck("R10 set wins", 8'h20, 3);
    busWrite(8'h20, 3);
    readCheck("R10 later clear", 8'h20, 0);
  endtask

  task automatic tCtrl();
    busWrite(8'h40, 32'hFFFF_FFFF);
    readCheck("R11 ctrl", 8'h40, 32'h8100_0000);
    check("R11 outputs", {30'b0, battEn, oscEn}, 3);
    busWrite(8'h40, 32'h0100_0000);
    check("R11 osc only", {30'b0, battEn, oscEn}, 1);
  endtask

  task automatic tUnmapped();
    busWrite(8'h1C, 32'hFFFF_FFFF);
    busWrite(8'h1A, 32'hFFFF_FFFF);
    busWrite(8'h30, 32'hFFFF_FFFF);
    readCheck("R12 read 1C", 8'h1C, 0);
    readCheck("R12 read 3C", 8'h3C, 0);
    readCheck("R12 misaligned", 8'h12, 0);
    readCheck("R12 alarm kept", 8'h18, 32'h100);
    readCheck("R12 ctrl kept", 8'h40, 32'h0100_0000);
    readCheck("R12 mask kept", 8'h24, 0);
    readCheck("R12 status kept", 8'h20, 0);
  endtask

  initial begin
    #(8 * 100000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tSetTime();
    tCalib();
    tCurrent();
    tAlarmReg();
    tStatus();
    tEnable();
    tIrq();
    tCollide();
    tCtrl();
    tUnmapped();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule